// File: doc/BRIEF.md
# Register-Triggered Dual-Port Peripheral Bus Bridge

This block is an APB slave with a 4 KiB register window. Software uses it to issue single read or write transactions on one of two downstream 32-bit peripheral-bus master ports. For each port, software loads a port-enable bit, a direction bit, a width code, a target address and write data. It then writes a launch register. The bridge checks the setup and runs one handshake on the chosen port. On a read, it latches the returned data into that port's read-back register. When the transaction completes it raises that port's completion bit in a shared status register, which drives the interrupt line.

Each downstream port holds its request, address, direction, width and write data steady until the target returns a one-cycle acknowledge or error. If neither arrives within a fixed number of cycles, the bridge counts the transaction as an error. Only one transaction can be outstanding at a time. Software can read a busy flag, and a launch written while busy has no effect.

Top module: `apb_opb_bridge`

## Requirements
- R1: APB accesses complete with zero wait states (pready high). An access whose paddr[1:0] is not 00 returns pslverr=1 in its access phase and alters no register. Such a read returns 0.
- R2: After reset, irq is 0 and the following registers read back as shown: 0x00 version = 0x000000A1, 0x4C = 0x0044EEE4, 0x50 = 0x0055AAFF, 0x54 = 0x00117717, 0x58 = 0xFFAA5500, 0x5C = 0x0044EEE4, 0x60 = 0x00117717, 0x48 status = 0, 0x04 busy = 0.
- R3: Per-port register offsets (port 0 / port 1) are enable 0x10/0x28, direction 0x14/0x2C, width 0x18/0x30, address 0x1C/0x34, write data 0x20/0x38 and read-back 0x84/0x90. The programmed address appears on dn_addr of the selected port.
- R4: Writing 0x04 with bit 0 set while idle starts exactly one transaction. Bit 0 of a 0x04 read is 1 while a transaction is outstanding.
- R5: A launch is rejected when the bit-0 enables of the two ports are not exactly one-hot. A rejected launch raises no dn_req and sets no status bit. At most one dn_req bit is ever high.
- R6: In the width register, bit 1 gives dn_size=2'b10 (32-bit). Otherwise bit 0 gives 2'b01 (16-bit). Neither bit gives 2'b00 (8-bit). Any set bit above bit 1 rejects the launch and raises no request.
- R7: Direction bit 0 = 1 makes a read (dn_wr=0). Bit 0 = 0 makes a write (dn_wr=1), and dn_wdata then carries the write-data register.
- R8: While dn_req is high and neither dn_ack nor dn_err is seen, the request and its address, direction and write data stay unchanged. dn_req falls on the cycle after dn_ack or dn_err.
- R9: A read that ends with dn_ack stores dn_rdata, zero-extended from its low 8 or 16 bits for those widths, into the port's read-back register.
- R10: A transaction that ends with dn_ack sets status bit 16 (port 0) or bit 17 (port 1). An error or timeout sets neither bit and leaves the read-back register unchanged.
- R11: A request with no response is dropped after exactly 1024 cycles high. It is then treated as an error and the bridge returns to idle.
- R12: Status bits clear when 1 is written to them; writing 0 leaves them unchanged. irq is high exactly when a status bit is set.
- R13: A launch written while a transaction is outstanding is ignored and starts no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 12 | APB byte address in the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error for unaligned accesses |
| irq | output | 1 | OR of status bits |
| dn_req | output | 2 | Per-port request |
| dn_addr | output | 2x32 | Per-port address |
| dn_wr | output | 2 | Per-port write flag |
| dn_size | output | 2x2 | Per-port width code |
| dn_wdata | output | 2x32 | Per-port write data |
| dn_rdata | input | 2x32 | Per-port read data, valid with ack |
| dn_ack | input | 2 | Per-port completion pulse |
| dn_err | input | 2 | Per-port error pulse |

## Verification
The assertions check the downstream handshake on every cycle. They cover the stability of held request fields, the release after a response, the bound on request length, that at most one port requests at a time, that slave errors occur only on unaligned accesses, and that every rise of irq follows an acknowledge. Only the bench scenarios can show the data-dependent behaviour: how the width code and direction are encoded, zero-extension of read data, rejected setups that leave no trace, clearing of individual status bits, and a launch being ignored during a long timeout.

// File: rtl/abr_pkg.sv
package abr_pkg;
  localparam int unsigned NPORT = 2;
  localparam int unsigned DW    = 32;
  localparam int unsigned NEND  = 6;

  localparam int unsigned IX_VERSION   = 'h00;
  localparam int unsigned IX_LAUNCH    = 'h01;
  localparam int unsigned IX_CTRL      = 'h02;
  localparam int unsigned IX_OFFS      = 'h03;
  localparam int unsigned IX_PORT_BASE = 'h04;
  localparam int unsigned IX_PORT_STEP = 'h06;
  localparam int unsigned IX_STATUS    = 'h12;
  localparam int unsigned IX_END_BASE  = 'h13;
  localparam int unsigned IX_RB_BASE   = 'h21;
  localparam int unsigned IX_RB_STEP   = 'h03;
  localparam int unsigned STS_LSB      = 16;

  localparam int unsigned F_EN    = 0;
  localparam int unsigned F_DIR   = 1;
  localparam int unsigned F_WIDTH = 2;
  localparam int unsigned F_ADDR  = 3;
  localparam int unsigned F_WDATA = 4;

  localparam logic [DW-1:0] VERSION_VAL = 32'h0000_00A1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } size_e;

  function automatic logic [9:0] port_ix(input int unsigned p, input int unsigned f);
    return 10'(IX_PORT_BASE + p * IX_PORT_STEP + f);
  endfunction

  function automatic logic [9:0] rb_ix(input int unsigned p);
    return 10'(IX_RB_BASE + p * IX_RB_STEP);
  endfunction

  function automatic logic [9:0] end_ix(input int unsigned k);
    return 10'(IX_END_BASE + k);
  endfunction

  function automatic logic [DW-1:0] end_reset(input int unsigned k);
    case (k)
      0:       return 32'h0044_EEE4;
      1:       return 32'h0055_AAFF;
      2:       return 32'h0011_7717;
      3:       return 32'hFFAA_5500;
      4:       return 32'h0044_EEE4;
      default: return 32'h0011_7717;
    endcase
  endfunction

  function automatic size_e width_code(input logic [1:0] w);
    if (w[1])      return SZ_WORD;
    else if (w[0]) return SZ_HALF;
    else           return SZ_BYTE;
  endfunction

  function automatic logic [DW-1:0] zext(input size_e s, input logic [DW-1:0] d);
    case (s)
      SZ_BYTE: return {24'h0, d[7:0]};
      SZ_HALF: return {16'h0, d[15:0]};
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/abr_master.sv
module abr_master
  import abr_pkg::*;
#(
  parameter int unsigned TIMEOUT = 1024,
  localparam int unsigned CW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] cfg_addr,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_size,
  input  logic [DW-1:0] cfg_wdata,
  output logic          busy,
  output logic          done,
  output logic          is_read,
  output logic [DW-1:0] rdata,
  output logic          dn_req,
  output logic [DW-1:0] dn_addr,
  output logic          dn_wr,
  output logic [1:0]    dn_size,
  output logic [DW-1:0] dn_wdata,
  input  logic [DW-1:0] dn_rdata,
  input  logic          dn_ack,
  input  logic          dn_err
);
  typedef enum logic {M_IDLE, M_WAIT} mst_e;

  mst_e          state_q, state_d;
  logic [DW-1:0] addr_q, wdata_q;
  logic          wr_q;
  size_e         size_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          load_en, tmo_hit, finish;

  assign load_en = start && (state_q == M_IDLE);
  assign tmo_hit = (cnt_q == CW'(TIMEOUT - 1));
  assign finish  = (state_q == M_WAIT) && (dn_ack || dn_err || tmo_hit);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      M_IDLE: begin
        if (start) begin
          state_d = M_WAIT;
          cnt_d   = '0;
        end
      end
      default: begin
        cnt_d = cnt_q + CW'(1);
        if (finish) state_d = M_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      size_q  <= SZ_BYTE;
    end else if (load_en) begin
      addr_q  <= cfg_addr;
      wdata_q <= cfg_wdata;
      wr_q    <= cfg_wr;
      size_q  <= size_e'(cfg_size);
    end
  end

  assign busy     = (state_q == M_WAIT);
  assign done     = busy && dn_ack && !dn_err;
  assign is_read  = !wr_q;
  assign rdata    = zext(size_q, dn_rdata);
  assign dn_req   = busy;
  assign dn_addr  = addr_q;
  assign dn_wr    = wr_q;
  assign dn_size  = size_q;
  assign dn_wdata = wdata_q;
endmodule

// File: rtl/abr_regs.sv
module abr_regs
  import abr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [11:0]                paddr,
  input  logic [DW-1:0]              pwdata,
  output logic [DW-1:0]              prdata,
  output logic                       pslverr,
  input  logic                       busy,
  input  logic [NPORT-1:0]           m_done,
  input  logic [NPORT-1:0]           m_read,
  input  logic [NPORT-1:0][DW-1:0]   m_rdata,
  output logic [NPORT-1:0]           start,
  output logic [NPORT-1:0][DW-1:0]   c_addr,
  output logic [NPORT-1:0]           c_wr,
  output logic [NPORT-1:0][1:0]      c_size,
  output logic [NPORT-1:0][DW-1:0]   c_wdata,
  output logic                       irq
);
  logic                      acc, aligned, wr_en, rd_en;
  logic [9:0]                idx;
  logic [DW-1:0]             ctrl_q, offs_q;
  logic [NPORT-1:0]          en_q, dir_q;
  logic [NPORT-1:0][DW-1:0]  width_q, addr_q, wdat_q, rb_q;
  logic [NEND-1:0][DW-1:0]   end_q;
  logic [NPORT-1:0]          sts_q, sts_d;
  logic [NPORT-1:0]          we_en, we_dir, we_width, we_addr, we_wdat, rb_en, width_ok;
  logic [NEND-1:0]           we_end;
  logic                      we_ctrl, we_offs, we_sts, we_launch, launch_ok;

  assign acc     = psel && penable;
  assign aligned = (paddr[1:0] == 2'b00);
  assign wr_en   = acc && pwrite && aligned;
  assign rd_en   = acc && !pwrite && aligned;
  assign idx     = paddr[11:2];
  assign pslverr = acc && !aligned;

  always_comb begin
    we_ctrl   = wr_en && (idx == 10'(IX_CTRL));
    we_offs   = wr_en && (idx == 10'(IX_OFFS));
    we_sts    = wr_en && (idx == 10'(IX_STATUS));
    we_launch = wr_en && (idx == 10'(IX_LAUNCH)) && pwdata[0];
    for (int p = 0; p < NPORT; p++) begin
      we_en[p]    = wr_en && (idx == port_ix(p, F_EN));
      we_dir[p]   = wr_en && (idx == port_ix(p, F_DIR));
      we_width[p] = wr_en && (idx == port_ix(p, F_WIDTH));
      we_addr[p]  = wr_en && (idx == port_ix(p, F_ADDR));
      we_wdat[p]  = wr_en && (idx == port_ix(p, F_WDATA));
      rb_en[p]    = m_done[p] && m_read[p];
      width_ok[p] = (width_q[p][DW-1:2] == '0);
    end
    for (int k = 0; k < NEND; k++) we_end[k] = wr_en && (idx == end_ix(k));
  end

  assign launch_ok = we_launch && !busy && $onehot(en_q);

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      start[p]   = launch_ok && en_q[p] && width_ok[p];
      c_addr[p]  = addr_q[p];
      c_wr[p]    = !dir_q[p];
      c_size[p]  = width_code(width_q[p][1:0]);
      c_wdata[p] = wdat_q[p];
      sts_d[p]   = m_done[p] || (sts_q[p] && !(we_sts && pwdata[STS_LSB + p]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      offs_q  <= '0;
      en_q    <= '0;
      dir_q   <= '0;
      width_q <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rb_q    <= '0;
      sts_q   <= '0;
      for (int k = 0; k < NEND; k++) end_q[k] <= end_reset(k);
    end else begin
      if (we_ctrl) ctrl_q <= pwdata;
      if (we_offs) offs_q <= pwdata;
      for (int p = 0; p < NPORT; p++) begin
        if (we_en[p])    en_q[p]    <= pwdata[0];
        if (we_dir[p])   dir_q[p]   <= pwdata[0];
        if (we_width[p]) width_q[p] <= pwdata;
        if (we_addr[p])  addr_q[p]  <= pwdata;
        if (we_wdat[p])  wdat_q[p]  <= pwdata;
        if (rb_en[p])    rb_q[p]    <= m_rdata[p];
      end
      for (int k = 0; k < NEND; k++) begin
        if (we_end[k]) end_q[k] <= pwdata;
      end
      sts_q <= sts_d;
    end
  end

  always_comb begin
    prdata = '0;
    if (rd_en) begin
      if (idx == 10'(IX_VERSION)) prdata = VERSION_VAL;
      if (idx == 10'(IX_LAUNCH))  prdata = {{(DW-1){1'b0}}, busy};
      if (idx == 10'(IX_CTRL))    prdata = ctrl_q;
      if (idx == 10'(IX_OFFS))    prdata = offs_q;
      if (idx == 10'(IX_STATUS))  prdata[STS_LSB +: NPORT] = sts_q;
      for (int p = 0; p < NPORT; p++) begin
        if (idx == port_ix(p, F_EN))    prdata = {{(DW-1){1'b0}}, en_q[p]};
        if (idx == port_ix(p, F_DIR))   prdata = {{(DW-1){1'b0}}, dir_q[p]};
        if (idx == port_ix(p, F_WIDTH)) prdata = width_q[p];
        if (idx == port_ix(p, F_ADDR))  prdata = addr_q[p];
        if (idx == port_ix(p, F_WDATA)) prdata = wdat_q[p];
        if (idx == rb_ix(p))            prdata = rb_q[p];
      end
      for (int k = 0; k < NEND; k++) begin
        if (idx == end_ix(k)) prdata = end_q[k];
      end
    end
  end

  assign irq = |sts_q;
endmodule

// File: rtl/apb_opb_bridge.sv
module apb_opb_bridge
  import abr_pkg::*;
#(
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [11:0]          paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  output logic                 pready,
  output logic                 pslverr,
  output logic                 irq,
  output logic [1:0]           dn_req,
  output logic [1:0][31:0]     dn_addr,
  output logic [1:0]           dn_wr,
  output logic [1:0][1:0]      dn_size,
  output logic [1:0][31:0]     dn_wdata,
  input  logic [1:0][31:0]     dn_rdata,
  input  logic [1:0]           dn_ack,
  input  logic [1:0]           dn_err
);
  logic [NPORT-1:0]          m_busy, m_done, m_read, start, c_wr;
  logic [NPORT-1:0][DW-1:0]  m_rdata, c_addr, c_wdata;
  logic [NPORT-1:0][1:0]     c_size;

  assign pready = 1'b1;

  abr_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .pslverr (pslverr),
    .busy    (|m_busy),
    .m_done  (m_done),
    .m_read  (m_read),
    .m_rdata (m_rdata),
    .start   (start),
    .c_addr  (c_addr),
    .c_wr    (c_wr),
    .c_size  (c_size),
    .c_wdata (c_wdata),
    .irq     (irq)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    abr_master #(.TIMEOUT(TIMEOUT)) u_mst (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start[p]),
      .cfg_addr  (c_addr[p]),
      .cfg_wr    (c_wr[p]),
      .cfg_size  (c_size[p]),
      .cfg_wdata (c_wdata[p]),
      .busy      (m_busy[p]),
      .done      (m_done[p]),
      .is_read   (m_read[p]),
      .rdata     (m_rdata[p]),
      .dn_req    (dn_req[p]),
      .dn_addr   (dn_addr[p]),
      .dn_wr     (dn_wr[p]),
      .dn_size   (dn_size[p]),
      .dn_wdata  (dn_wdata[p]),
      .dn_rdata  (dn_rdata[p]),
      .dn_ack    (dn_ack[p]),
      .dn_err    (dn_err[p])
    );
  end
endmodule

// File: rtl/abr_checker.sv
module abr_checker #(
  parameter int unsigned TIMEOUT = 1024,
  localparam int unsigned CW = $clog2(TIMEOUT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             psel,
  input logic             penable,
  input logic [11:0]      paddr,
  input logic             pslverr,
  input logic             irq,
  input logic [1:0]       dn_req,
  input logic [1:0][31:0] dn_addr,
  input logic [1:0]       dn_wr,
  input logic [1:0][31:0] dn_wdata,
  input logic [1:0]       dn_ack,
  input logic [1:0]       dn_err
);
  p_one_port_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dn_req));

  p_slverr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (psel && penable && (paddr[1:0] != 2'b00)));

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(dn_req & dn_ack & ~dn_err)));

  for (genvar p = 0; p < 2; p++) begin : g_chk
    logic [CW-1:0] held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held_q <= '0;
      else if (dn_req[p]) held_q <= held_q + CW'(1);
      else                held_q <= '0;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req[p] && !dn_ack[p] && !dn_err[p] && (held_q != CW'(TIMEOUT - 1)))
      |=> (dn_req[p] && $stable(dn_addr[p]) && $stable(dn_wr[p]) && $stable(dn_wdata[p])));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_req[p] && (dn_ack[p] || dn_err[p])) |=> !dn_req[p]);

    p_timeout_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req[p] |-> (held_q <= CW'(TIMEOUT - 1)));
  end
endmodule

bind apb_opb_bridge abr_checker #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .psel     (psel),
  .penable  (penable),
  .paddr    (paddr),
  .pslverr  (pslverr),
  .irq      (irq),
  .dn_req   (dn_req),
  .dn_addr  (dn_addr),
  .dn_wr    (dn_wr),
  .dn_wdata (dn_wdata),
  .dn_ack   (dn_ack),
  .dn_err   (dn_err)
);

// File: tb/apb_opb_bridge_test.sv
module apb_opb_bridge_test;
  logic             clk, rst_n;
  logic             psel, penable, pwrite;
  logic [11:0]      paddr;
  logic [31:0]      pwdata, prdata;
  logic             pready, pslverr, irq;
  logic [1:0]       dn_req, dn_wr, dn_ack, dn_err;
  logic [1:0][31:0] dn_addr, dn_wdata, dn_rdata;
  logic [1:0][1:0]  dn_size;

  int          n_total, n_pass;
  int          req_cnt [2];
  int          hold_len [2];
  logic [31:0] cap_addr [2];
  logic [31:0] cap_wdata [2];
  logic        cap_wr [2];
  logic [1:0]  cap_size [2];
  logic [31:0] q;
  logic        e;

  apb_opb_bridge uut (.*);

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  function automatic logic [31:0] resp(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hA5A5_0F0F;
  endfunction

  function automatic logic [1:0] exp_code(input logic [31:0] w);
    return w[1] ? 2'b10 : (w[0] ? 2'b01 : 2'b00);
  endfunction

  function automatic logic [31:0] exp_ext(input logic [31:0] w, input logic [31:0] d);
    return w[1] ? d : (w[0] ? {16'h0, d[15:0]} : {24'h0, d[7:0]});
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
  endtask

  task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic err);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd  = prdata;
    err = pslverr;
    if (pready !== 1'b1) chk(1'b0, "R1 pready", 32'(pready), 32'h1);
    @(posedge clk);
    #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] t; logic te;
    apb(1'b1, a, d, t, te);
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] d);
    logic te;
    apb(1'b0, a, 32'h0, d, te);
  endtask

  task automatic wait_idle;
    logic [31:0] t;
    for (int i = 0; i < 3000; i++) begin
      rd32(12'h004, t);
      if (!t[0]) break;
    end
  endtask

  task automatic responder(input int p);
    forever begin
      @(negedge clk);
      if (dn_req[p]) begin
        req_cnt[p]++;
        cap_addr[p]  = dn_addr[p];
        cap_wdata[p] = dn_wdata[p];
        cap_wr[p]    = dn_wr[p];
        cap_size[p]  = dn_size[p];
        if (dn_addr[p][31:28] == 4'hD) begin
          hold_len[p] = 0;
          while (dn_req[p]) begin
            hold_len[p]++;
            @(negedge clk);
          end
        end else begin
          repeat ($urandom_range(0, 4)) @(negedge clk);
          if (dn_addr[p][31:28] == 4'hE) dn_err[p] = 1'b1;
          else begin
            dn_ack[p]   = 1'b1;
            dn_rdata[p] = resp(dn_addr[p]);
          end
          @(negedge clk);
          dn_ack[p] = 1'b0;
          dn_err[p] = 1'b0;
          dn_rdata[p] = 32'h0;
        end
      end
    end
  endtask

  initial responder(0);
  initial responder(1);

  task automatic setup(input int p, input logic rd, input logic [31:0] w,
                       input logic [31:0] a, input logic [31:0] d);
    logic [11:0] b;
    b = (p == 0) ? 12'h010 : 12'h028;
    wr32(12'h010, (p == 0) ? 32'h1 : 32'h0);
    wr32(12'h028, (p == 1) ? 32'h1 : 32'h0);
    wr32(b + 12'h4, {31'h0, rd});
    wr32(b + 12'h8, w);
    wr32(b + 12'hC, a);
    wr32(b + 12'h10, d);
  endtask

  task automatic run_txn(input int p, input logic rd, input logic [31:0] w,
                         input logic [31:0] a, input logic [31:0] d, input logic clr);
    int c0;
    logic [31:0] t;
    setup(p, rd, w, a, d);
    c0 = req_cnt[p];
    wr32(12'h004, 32'h1);
    wait_idle();
    chk(req_cnt[p] == c0 + 1, "R4 one request", 32'(req_cnt[p] - c0), 32'h1);
    chk(cap_addr[p] == a, "R3 address", cap_addr[p], a);
    chk(cap_wr[p] == !rd, "R7 direction", 32'(cap_wr[p]), 32'(!rd));
    chk(cap_size[p] == exp_code(w), "R6 width code", 32'(cap_size[p]), 32'(exp_code(w)));
    if (!rd) chk(cap_wdata[p] == d, "R7 write data", cap_wdata[p], d);
    else begin
      rd32((p == 0) ? 12'h084 : 12'h090, t);
      chk(t == exp_ext(w, resp(a)), "R9 read-back", t, exp_ext(w, resp(a)));
    end
    rd32(12'h048, t);
    chk(t[16 + p] == 1'b1, "R10 ack bit", t, 32'(1) << (16 + p));
    chk(irq == 1'b1, "R12 irq set", 32'(irq), 32'h1);
    if (clr) begin
      wr32(12'h048, 32'hFFFF_FFFF);
      rd32(12'h048, t);
      chk(t == 32'h0 && irq == 1'b0, "R12 clear", t, 32'h0);
    end
  endtask

  initial begin
    logic [31:0] t, rb;
    logic [31:0] end_exp [6];
    int c0;
    void'($urandom(32'd1234));
    end_exp = '{32'h0044EEE4, 32'h0055AAFF, 32'h00117717, 32'hFFAA5500, 32'h0044EEE4, 32'h00117717};
    n_total = 0; n_pass = 0;
    req_cnt = '{0, 0}; hold_len = '{0, 0};
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    dn_ack = '0; dn_err = '0; dn_rdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 reset state
    chk(irq == 1'b0, "R2 irq", 32'(irq), 32'h0);
    rd32(12'h000, t); chk(t == 32'hA1, "R2 version", t, 32'hA1);
    for (int k = 0; k < 6; k++) begin
      rd32(12'(12'h04C + 4 * k), t);
      chk(t == end_exp[k], "R2 endian cfg", t, end_exp[k]);
    end
    rd32(12'h048, t); chk(t == 32'h0, "R2 status", t, 32'h0);
    rd32(12'h004, t); chk(t == 32'h0, "R2 busy", t, 32'h0);

    // R1 unaligned
    wr32(12'h01C, 32'h1234_5678);
    apb(1'b1, 12'h01E, 32'hDEAD_BEEF, t, e);
    chk(e == 1'b1, "R1 pslverr write", 32'(e), 32'h1);
    rd32(12'h01C, t); chk(t == 32'h1234_5678, "R1 write dropped", t, 32'h1234_5678);
    apb(1'b0, 12'h001, 32'h0, t, e);
    chk(e == 1'b1 && t == 32'h0, "R1 pslverr read", t, 32'h0);

    // R5 both or neither enable
    setup(0, 1'b1, 32'h2, 32'h1000_0040, 32'h0);
    wr32(12'h028, 32'h1);
    c0 = req_cnt[0] + req_cnt[1];
    wr32(12'h004, 32'h1);
    repeat (8) @(negedge clk);
    chk(req_cnt[0] + req_cnt[1] == c0, "R5 both enabled", 32'(req_cnt[0] + req_cnt[1] - c0), 32'h0);
    wr32(12'h010, 32'h0); wr32(12'h028, 32'h0);
    wr32(12'h004, 32'h1);
    repeat (8) @(negedge clk);
    chk(req_cnt[0] + req_cnt[1] == c0, "R5 none enabled", 32'(req_cnt[0] + req_cnt[1] - c0), 32'h0);
    rd32(12'h048, t); chk(t == 32'h0, "R5 no status", t, 32'h0);

    // R6 reserved width bits
    setup(1, 1'b1, 32'h6, 32'h1000_0080, 32'h0);
    wr32(12'h004, 32'h1);
    repeat (8) @(negedge clk);
    chk(req_cnt[1] == 0, "R6 bad width rejected", 32'(req_cnt[1]), 32'h0);

    // Directed widths, both ports, no clearing between (R12 partial clear)
    run_txn(0, 1'b1, 32'h0, 32'h2000_1234, 32'h0, 1'b0);
    run_txn(1, 1'b1, 32'h1, 32'h3000_5678, 32'h0, 1'b0);
    wr32(12'h048, 32'h0000_0000);
    rd32(12'h048, t); chk(t == 32'h0003_0000, "R12 zero write keeps", t, 32'h0003_0000);
    wr32(12'h048, 32'h0001_0000);
    rd32(12'h048, t); chk(t == 32'h0002_0000 && irq, "R12 w1c single", t, 32'h0002_0000);
    wr32(12'h048, 32'h0002_0000);
    chk(irq == 1'b0, "R12 irq low", 32'(irq), 32'h0);

    // R10 error response
    rd32(12'h084, rb);
    setup(0, 1'b1, 32'h2, 32'hE000_0010, 32'h0);
    wr32(12'h004, 32'h1);
    wait_idle();
    rd32(12'h048, t); chk(t == 32'h0, "R10 error no ack", t, 32'h0);
    rd32(12'h084, t); chk(t == rb, "R10 read-back kept", t, rb);

    // R11 timeout, R13 launch while busy
    setup(0, 1'b0, 32'h2, 32'hD000_0020, 32'hCAFE_0001);
    c0 = req_cnt[0];
    wr32(12'h004, 32'h1);
    rd32(12'h004, t); chk(t[0] == 1'b1, "R4 busy flag", t, 32'h1);
    wr32(12'h004, 32'h1);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(hold_len[0] == 1024, "R11 timeout length", 32'(hold_len[0]), 32'd1024);
    chk(req_cnt[0] == c0 + 1, "R13 relaunch ignored", 32'(req_cnt[0] - c0), 32'h1);
    rd32(12'h048, t); chk(t == 32'h0, "R11 no ack", t, 32'h0);

    // Random transactions
    for (int i = 0; i < 40; i++) begin
      int p;
      logic [31:0] a, w;
      p = int'($urandom_range(0, 1));
      w = 32'($urandom_range(0, 3));
      a = {4'($urandom_range(1, 12)), 28'($urandom)};
      run_txn(p, 1'($urandom_range(0, 1)), w, a, $urandom, 1'b1);
    end

    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_total++;
    $display("FAIL watchdog R4 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule